// File: doc/BRIEF.md
# Dual-Master Interrupt Status Register

This block holds the interrupt status seen by each of the two upstream masters of a bus selector. Each master has its own 8-bit status copy behind the same register address. A read issued by master m returns copy m and never the other master's copy. Two kinds of bits share each copy. Level bits follow their sources: the external active-low interrupt line, the master's own test flag, and the other master's cross-test flag. Sticky bits latch one-cycle event pulses: recovery finished, bus busy at a switch, and switch-away started. A sticky bit stays set until the owning master reads the register.

A read begins with a `rd_start` pulse. On that pulse the copy is captured into a per-master read buffer, and the buffer drives the read data until the next read begins. The serial slave shifts this byte out and gives one `rd_bit` pulse per bit clock. The second bit clock of a read clears that master's sticky bits. A set event in the same cycle wins over the clear. Each master's interrupt request is the OR of its status bits, each bit gated by its own enable input.

Top module: `irq_status_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status bit, both read buffers and both interrupt requests go to 0.
- R2: Master m's copy sits in `rd_data[8m+7:8m]` and is captured only by `rd_start[m]`. Events, tests and reads of one master leave the other master's copy unchanged, except the cross-test bit defined in R5.
- R3: Bit layout of a copy: [7] cross-test, [6] own test, [3] switch-away, [2] busy-at-switch, [1] recovery-done, [0] external interrupt. Bits [5:4] always read 0.
- R4: Bit 0 of both copies equals the inverse of `ext_int_n` sampled at the previous clock edge. A read does not clear it.
- R5: Bit 6 of copy m follows `own_test[m]`, and bit 7 of copy m follows `cross_test` of the other master, each one clock late. A read clears neither bit.
- R6: An `evt_init_done[m]` pulse sets bit 1 of copy m at the next edge. The bit then holds until it is cleared by a read.
- R7: An `evt_busy_switch[m]` pulse sets bit 2 of copy m at the next edge, unless `recov_req` is high in the same cycle.
- R8: An `evt_switch_away[m]` pulse sets bit 3 of copy m at the next edge. The pulse is driven on the index of the master being switched away from.
- R9: Bits 1 to 3 of copy m clear at the edge of the second `rd_bit[m]` pulse after `rd_start[m]`. Other `rd_bit` pulses, including pulses outside any read, have no effect.
- R10: A set event in the same cycle as the clearing pulse leaves its bit set.
- R11: `rd_data` for master m is captured from the copy at the `rd_start[m]` edge. It stays constant until the next `rd_start[m]`, whatever the copy does meanwhile.
- R12: `irq[m]` is the OR over bits b of copy bit b AND `int_en[8m+b]`. A still-low external line keeps the request raised after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | 1 | External interrupt line, active low |
| recov_req | input | 1 | Bus recovery requested; blocks busy-at-switch setting |
| evt_init_done | input | 2 | Per-master pulse: recovery/initialization finished |
| evt_busy_switch | input | 2 | Per-master pulse: bus was not idle at a switch |
| evt_switch_away | input | 2 | Per-master pulse: switch away from this master started |
| own_test | input | 2 | Each master's own test flag |
| cross_test | input | 2 | Each master's test flag aimed at the other master |
| int_en | input | 16 | Per-bit interrupt enables, byte m for master m |
| rd_start | input | 2 | Per-master pulse: status read begins |
| rd_bit | input | 2 | Per-master pulse: one read bit clock |
| rd_data | output | 16 | Captured read byte, byte m for master m |
| irq | output | 2 | Interrupt request per master |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next. The external-interrupt bit follows the line, and a sticky bit holds until its clearing pulse. A set event wins over the clear, recovery blocks the busy-at-switch bit, read data stays put between captures, and the reserved bits stay zero. Only the bench's scenarios can show the behaviour that needs a sequence of cycles. These are that the clear comes on exactly the second bit clock and not the first, that stray bit clocks outside a read are ignored, and that a read by one master leaves the other copy alone. They also cover the captured byte staying fixed while the copy changes, and the request staying raised after a read while the line is still low.

// File: rtl/irqsp_pkg.sv
// Shared constants and types for the dual-master interrupt status register.
package irqsp_pkg;
    localparam int STAT_W    = 8;
    localparam int BIT_EXT   = 0;
    localparam int BIT_INIT  = 1;
    localparam int BIT_BUSY  = 2;
    localparam int BIT_LOST  = 3;
    localparam int BIT_OWN   = 6;
    localparam int BIT_CROSS = 7;
    localparam int N_STICKY  = 3;

    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/irqsp_level_track.sv
// Registers the level-tracked bits of one status copy.
// Assumes: inputs are synchronous to clk; each bit follows its source one clock late.
module irqsp_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_low,
    input  logic own_t,
    input  logic cross_t,
    output logic ext_q,
    output logic own_q,
    output logic cross_q
);
    // Sample the three level sources each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q   <= 1'b0;
            own_q   <= 1'b0;
            cross_q <= 1'b0;
        end else begin
            ext_q   <= ext_low;
            own_q   <= own_t;
            cross_q <= cross_t;
        end
    end
endmodule

// File: rtl/irqsp_sticky.sv
// Event-latched status bits with a common clear; a set wins over the clear in the same cycle.
// Assumes: set inputs are one-cycle pulses; clr is a one-cycle pulse.
module irqsp_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    // Hold, clear or set each bit; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= set | (q & ~{N{clr}});
        end
    end
endmodule

// File: rtl/irqsp_rd_seq.sv
// Per-master read sequencer: captures the copy at read start and counts bit clocks.
// Its clear output fires on the CLR_PULSE-th bit clock of a read.
// Assumes: rd_start begins a read; bit clocks beyond CLR_PULSE or outside a read do nothing.
module irqsp_rd_seq
    import irqsp_pkg::*;
#(
    parameter int CLR_PULSE = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_start,
    input  logic  rd_bit,
    input  stat_t stat_in,
    output stat_t rd_data,
    output logic  clr
);
    localparam int             CNT_W = $clog2(CLR_PULSE + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(CLR_PULSE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_PULSE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Clear pulse on the edge of the last counted bit clock.
    always_comb begin
        clr = !rd_start && rd_bit && (cnt_q == LAST);
    end

    // Capture the byte at read start and count bit clocks until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= IDLE;
            rd_data <= '0;
        end else if (rd_start) begin
            cnt_q   <= '0;
            rd_data <= stat_in;
        end else if (rd_bit && (cnt_q != IDLE)) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/irqsp_irq_gate.sv
// Combines one status copy with its per-bit enables into an interrupt request.
module irqsp_irq_gate
    import irqsp_pkg::*;
(
    input  stat_t stat,
    input  stat_t en,
    output logic  irq
);
    // OR of enabled status bits.
    always_comb begin
        irq = |(stat & en);
    end
endmodule

// File: rtl/irq_status_pair.sv
// Two interrupt status copies, one per upstream master, behind one address.
// Assumes: event inputs are one-cycle pulses; NUM_MASTERS is 2, and master m's peer is (m+1)%NUM_MASTERS.
module irq_status_pair
    import irqsp_pkg::*;
#(
    parameter int NUM_MASTERS = 2,
    parameter int CLR_PULSE   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ext_int_n,
    input  logic                          recov_req,
    input  logic [NUM_MASTERS-1:0]        evt_init_done,
    input  logic [NUM_MASTERS-1:0]        evt_busy_switch,
    input  logic [NUM_MASTERS-1:0]        evt_switch_away,
    input  logic [NUM_MASTERS-1:0]        own_test,
    input  logic [NUM_MASTERS-1:0]        cross_test,
    input  logic [NUM_MASTERS*STAT_W-1:0] int_en,
    input  logic [NUM_MASTERS-1:0]        rd_start,
    input  logic [NUM_MASTERS-1:0]        rd_bit,
    output logic [NUM_MASTERS*STAT_W-1:0] rd_data,
    output logic [NUM_MASTERS-1:0]        irq
);
    logic [NUM_MASTERS*STAT_W-1:0] status_q;
    logic [NUM_MASTERS-1:0]        clr_pulse;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        localparam int PEER = (m + 1) % NUM_MASTERS;

        logic                ext_q, own_q, cross_q;
        logic [N_STICKY-1:0] sticky_set, sticky_q;
        stat_t               copy_w, rd_w;

        irqsp_level_track u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .ext_low (!ext_int_n),
            .own_t   (own_test[m]),
            .cross_t (cross_test[PEER]),
            .ext_q   (ext_q),
            .own_q   (own_q),
            .cross_q (cross_q)
        );

        // Event pulses mapped onto sticky bits; recovery request blocks busy-at-switch.
        always_comb begin
            sticky_set = {evt_switch_away[m],
                          evt_busy_switch[m] & !recov_req,
                          evt_init_done[m]};
        end

        irqsp_sticky #(.N(N_STICKY)) u_sticky (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (sticky_set),
            .clr   (clr_pulse[m]),
            .q     (sticky_q)
        );

        // Assemble the copy in its bit layout; reserved bits are zero.
        always_comb begin
            copy_w            = '0;
            copy_w[BIT_EXT]   = ext_q;
            copy_w[BIT_INIT]  = sticky_q[0];
            copy_w[BIT_BUSY]  = sticky_q[1];
            copy_w[BIT_LOST]  = sticky_q[2];
            copy_w[BIT_OWN]   = own_q;
            copy_w[BIT_CROSS] = cross_q;
        end

        irqsp_rd_seq #(.CLR_PULSE(CLR_PULSE)) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_start (rd_start[m]),
            .rd_bit   (rd_bit[m]),
            .stat_in  (copy_w),
            .rd_data  (rd_w),
            .clr      (clr_pulse[m])
        );

        irqsp_irq_gate u_irq (
            .stat (copy_w),
            .en   (int_en[m*STAT_W +: STAT_W]),
            .irq  (irq[m])
        );

        assign status_q[m*STAT_W +: STAT_W] = copy_w;
        assign rd_data[m*STAT_W +: STAT_W]  = rd_w;
    end
endmodule

// File: rtl/irq_status_pair_chk.sv
// Assertion checker for irq_status_pair, attached with bind.
module irq_status_pair_chk #(
    parameter int NM = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_int_n,
    input logic            recov_req,
    input logic [NM-1:0]   evt_init_done,
    input logic [NM-1:0]   evt_busy_switch,
    input logic [NM-1:0]   rd_start,
    input logic [NM-1:0]   clr_pulse,
    input logic [NM*8-1:0] stat,
    input logic [NM*8-1:0] rd_data,
    input logic [NM-1:0]   irq
);
    for (genvar m = 0; m < NM; m++) begin : g_chk
        localparam int B = m * 8;

        // R4
        ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ext_int_n |=> stat[B]);

        // R3
        reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[B+4 +: 2] == 2'b00);

        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[B+1] && !clr_pulse[m]) |=> stat[B+1]);

        // R9
        sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pulse[m] && !evt_init_done[m]) |=> !stat[B+1]);

        // R10
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_init_done[m] |=> stat[B+1]);

        // R7
        busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_busy_switch[m] && recov_req && !stat[B+2]) |=> !stat[B+2]);

        // R11
        hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_start[m] |=> $stable(rd_data[B +: 8]));

        // R12
        irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[B +: 8] == 8'h00) |-> !irq[m]);
    end
endmodule

bind irq_status_pair irq_status_pair_chk #(.NM(NUM_MASTERS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ext_int_n       (ext_int_n),
    .recov_req       (recov_req),
    .evt_init_done   (evt_init_done),
    .evt_busy_switch (evt_busy_switch),
    .rd_start        (rd_start),
    .clr_pulse       (clr_pulse),
    .stat            (status_q),
    .rd_data         (rd_data),
    .irq             (irq)
);

// File: tb/tb_irq_status_pair.sv
// Bench: behavioural reference model compared every clock, plus directed scenarios.
module tb_irq_status_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_int_n = 1'b1;
    logic        recov_req = 1'b0;
    logic [1:0]  evt_init_done = '0, evt_busy_switch = '0, evt_switch_away = '0;
    logic [1:0]  own_test = '0, cross_test = '0;
    logic [15:0] int_en = 16'hFFFF;
    logic [1:0]  rd_start = '0, rd_bit = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_status_pair dut (
        .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n), .recov_req(recov_req),
        .evt_init_done(evt_init_done), .evt_busy_switch(evt_busy_switch),
        .evt_switch_away(evt_switch_away), .own_test(own_test), .cross_test(cross_test),
        .int_en(int_en), .rd_start(rd_start), .rd_bit(rd_bit),
        .rd_data(rd_data), .irq(irq)
    );

    // Reference model state
    int st[2];
    int cnt[2];
    int sh[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < 2; m++) begin
                st[m] = 0; cnt[m] = 2; sh[m] = 0;
            end
        end else begin
            for (int m = 0; m < 2; m++) begin
                int nx;
                bit wipe;
                nx = st[m];
                wipe = !rd_start[m] && rd_bit[m] && (cnt[m] == 1);
                if (wipe) nx = nx & ~32'h0E;
                nx = nx & ~32'hC1;
                if (!ext_int_n) nx = nx | 32'h01;
                if (own_test[m]) nx = nx | 32'h40;
                if (cross_test[1-m]) nx = nx | 32'h80;
                if (evt_init_done[m]) nx = nx | 32'h02;
                if (evt_busy_switch[m] && !recov_req) nx = nx | 32'h04;
                if (evt_switch_away[m]) nx = nx | 32'h08;
                if (rd_start[m]) begin
                    sh[m] = st[m]; cnt[m] = 0;
                end else if (rd_bit[m] && cnt[m] < 2) begin
                    cnt[m] = cnt[m] + 1;
                end
                st[m] = nx;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R2 read data per copy, R12 requests).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int m = 0; m < 2; m++) begin
                chk("R2 model rd_data", int'(rd_data[m*8 +: 8]), sh[m]);
                chk("R12 model irq", int'(irq[m]), int'((st[m] & int'(int_en[m*8 +: 8])) != 0));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int m, output logic [7:0] b);
        rd_start[m] = 1'b1;
        tick(1);
        rd_start[m] = 1'b0;
        b = rd_data[m*8 +: 8];
    endtask

    task automatic bitclk(input int m);
        rd_bit[m] = 1'b1;
        tick(1);
        rd_bit[m] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, held;
        tick(3);
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        tick(1);

        // R4 external line level, not cleared by read
        ext_int_n = 1'b0;
        tick(1);
        rd(0, b); chk("R4 set copy0", b, 8'h01);
        rd(1, b); chk("R4 set copy1", b, 8'h01);
        chk("R12 irq on ext", int'(irq), 3);
        rd(0, b); bitclk(0); bitclk(0); tick(1);
        rd(0, b); chk("R4 survives read", b, 8'h01);
        chk("R12 irq re-raised", int'(irq[0]), 1);
        ext_int_n = 1'b1;
        tick(1);
        rd(0, b); chk("R4 clears on high", b, 8'h00);

        // R5 test bits
        own_test[0] = 1'b1; cross_test[0] = 1'b1;
        tick(1);
        rd(0, b); chk("R5 own test copy0", b, 8'h40);
        rd(1, b); chk("R5 cross test copy1", b, 8'h80);
        own_test = '0; cross_test = '0;
        tick(1);

        // R7 busy-at-switch with and without recovery request
        recov_req = 1'b1; evt_busy_switch[0] = 1'b1; tick(1);
        recov_req = 1'b0; evt_busy_switch[0] = 1'b0;
        rd(0, b); chk("R7 masked by recovery", b, 8'h00);
        evt_busy_switch[0] = 1'b1; tick(1); evt_busy_switch[0] = 1'b0;
        rd(0, b); chk("R7 set", b, 8'h04);

        // R6 recovery done, R2 copies independent
        evt_init_done[1] = 1'b1; tick(1); evt_init_done[1] = 1'b0;
        rd(1, b); chk("R6 set copy1", b, 8'h02);
        rd(0, b); chk("R2 copy0 untouched", b, 8'h04);

        // R8 switch-away
        evt_switch_away[0] = 1'b1; tick(1); evt_switch_away[0] = 1'b0;
        rd(0, b); chk("R8 set copy0", b, 8'h0C);

        // R9 clear on the second bit clock only
        int_en = 16'h0E0E;
        chk("R9 pre-clear irq", int'(irq), 3);
        bitclk(0);
        chk("R9 first bitclk keeps", int'(irq[0]), 1);
        bitclk(0);
        chk("R9 second bitclk clears", int'(irq[0]), 0);
        chk("R2 copy1 still set", int'(irq[1]), 1);
        bitclk(0);
        chk("R9 extra bitclk harmless", int'(irq[0]), 0);

        // R9 stray bit clocks outside a read
        bitclk(1); bitclk(1);
        chk("R9 copy1 cleared", int'(irq[1]), 0);
        evt_init_done[1] = 1'b1; tick(1); evt_init_done[1] = 1'b0;
        bitclk(1); bitclk(1); bitclk(1);
        chk("R9 stray bitclk ignored", int'(irq[1]), 1);

        // R10 set wins over clear in the same cycle
        rd(1, b); bitclk(1);
        rd_bit[1] = 1'b1; evt_init_done[1] = 1'b1;
        tick(1);
        rd_bit[1] = 1'b0; evt_init_done[1] = 1'b0;
        chk("R10 set wins", int'(irq[1]), 1);

        // R11 captured byte holds while copy changes
        rd(1, held);
        own_test[1] = 1'b1;
        tick(2);
        chk("R11 byte held", int'(rd_data[15:8]), int'(held));
        own_test[1] = 1'b0;
        tick(1);

        // R3 full layout and reserved bits
        ext_int_n = 1'b0; own_test = 2'b11; cross_test = 2'b11;
        evt_init_done[0] = 1'b1; evt_busy_switch[0] = 1'b1; evt_switch_away[0] = 1'b1;
        tick(1);
        evt_init_done[0] = 1'b0; evt_busy_switch[0] = 1'b0; evt_switch_away[0] = 1'b0;
        rd(0, b); chk("R3 layout all set", b, 8'hCF);
        int_en = 16'h3030;
        tick(1);
        chk("R3 reserved bits give no irq", int'(irq), 0);
        tick(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule